// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays one small, freely positioned pointer image over a pixel stream in which video and graphics are already combined. The pointer image lives in a fixed store of 1024 pixel cells. Each cell holds a 2-bit colour index. The same store can be read as one of five rectangles, from tall and narrow to short and wide. Each index picks one of four colour entries. An entry gives a luma value, two chroma values and a 2-bit opacity. The opacity mixes the pointer colour into the pixel beneath it in four steps, from unchanged to fully covered.

The display pipeline presents each pixel together with its screen coordinates. The block compares those coordinates with the active pointer rectangle and returns the pixel two clock cycles later, either blended or untouched. Software loads the image cells, the colour entries, the position and the shape through a single write port. Position, shape and enable are held in a pending copy and reach the active copy only when a field-start pulse arrives. Image cells and colour entries take effect at once.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, `out_valid` and all output components are 0, and the pointer is disabled, so every pixel passes through unchanged.
- R2: Every pixel leaves exactly two clock cycles after it enters. `out_valid` repeats `pix_valid` with a delay of two cycles.
- R3: A pixel outside the active rectangle, or any pixel while the pointer is disabled, is output with its input components unchanged.
- R4: Shape code s (control bits [2:0]) sets the width to 8·2^s and the height to 128/2^s: 0 gives 8×128, 1 gives 16×64, 2 gives 32×32, 3 gives 64×16 and 4 gives 128×8. Codes 5, 6 and 7 behave as code 4.
- R5: A pixel at column c and row r inside the rectangle, counted from the top-left corner at (X, Y), uses image cell r·width + c. A write with `reg_addr[10]`=1 stores `reg_wdata[1:0]` into cell `reg_addr[9:0]`.
- R6: With `reg_addr[10]`=0, `reg_addr[2:0]` selects the target: 0 is X, 1 is Y, 2 is control ([2:0] shape, [3] enable), and 4 to 7 are colour entries 0 to 3. An entry word holds Y in [15:10], U in [9:6], V in [5:2] and opacity T in [1:0]. Y is widened to 8 bits as {Y, Y[5:4]}, and U and V are widened as {U, U} and {V, V}.
- R7: Inside the rectangle, each output component is floor((cursor·T + pixel·(3−T)) / 3). T=0 leaves the pixel unchanged and T=3 gives the cursor colour only.
- R8: Writes to X, Y and control take effect only on a clock edge where `field_start` is 1. A pixel presented in that same cycle still uses the old settings.
- R9: Writes to colour entries and image cells apply to every pixel presented after the write cycle, with no field start needed.
- R10: The rectangle is clipped at the coordinate limits and does not wrap. A pointer placed near the right or bottom limit covers no pixel near coordinate 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_x | input | X_W | Column of the input pixel |
| pix_y | input | Y_W | Row of the input pixel |
| field_start | input | 1 | Pulse that loads the pending position, shape and enable |
| in_y | input | 8 | Input luma |
| in_u | input | 8 | Input chroma U |
| in_v | input | 8 | Input chroma V |
| reg_we | input | 1 | Register or image-cell write strobe |
| reg_addr | input | 11 | Write target: bit 10 selects the image store |
| reg_wdata | input | 16 | Write data |
| out_valid | output | 1 | Output pixel qualifier |
| out_y | output | 8 | Output luma |
| out_u | output | 8 | Output chroma U |
| out_v | output | 8 | Output chroma V |

## Verification
Each pixel result is due on the second rising edge after the pixel is driven: one edge for the image read and the position compare, one for the blend. The bench drives one pixel per cycle on the falling edge. On that same falling edge it compares the outputs with an expectation it computed two cycles earlier and held in a two-entry history. Register and image writes take one edge, and the field-start load happens on the edge where the pulse is seen. For this reason the bench updates its model of the active settings only after it has computed the expectation for the pixel driven with the pulse.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int CUR_ALOG       = 10;
  localparam int CUR_MIN_WLOG   = 3;
  localparam int CUR_LAST_SHAPE = 4;
  localparam int CLUT_N         = 4;
  localparam int CLUT_W         = 16;

  typedef struct packed {
    logic [5:0] y;
    logic [3:0] u;
    logic [3:0] v;
    logic [1:0] t;
  } clut_entry_t;

  function automatic logic [2:0] shape_clamp(input logic [2:0] sel);
    return (sel > 3'(CUR_LAST_SHAPE)) ? 3'(CUR_LAST_SHAPE) : sel;
  endfunction

  function automatic logic [3:0] width_log(input logic [2:0] sel);
    return 4'(CUR_MIN_WLOG) + {1'b0, shape_clamp(sel)};
  endfunction

  function automatic logic [3:0] height_log(input logic [2:0] sel);
    return 4'(CUR_ALOG) - width_log(sel);
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] c);
    return {c, c[5:4]};
  endfunction

  function automatic logic [7:0] widen4(input logic [3:0] c);
    return {c, c};
  endfunction

  function automatic logic [7:0] blend3(input logic [7:0] cur, input logic [7:0] pix,
                                        input logic [1:0] t);
    logic [9:0] acc;
    acc = 10'(cur) * 10'(t) + 10'(pix) * 10'(2'd3 - t);
    return 8'(acc / 10'd3);
  endfunction
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int X_W = 11,
  parameter int Y_W = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctl_we,
  input  logic [2:0]                    ctl_addr,
  input  logic [CLUT_W-1:0]             wdata,
  input  logic                          field_start,
  output logic [X_W-1:0]                act_x,
  output logic [Y_W-1:0]                act_y,
  output logic [2:0]                    act_sel,
  output logic                          act_en,
  output clut_entry_t [CLUT_N-1:0]      clut
);
  logic [X_W-1:0] pend_x;
  logic [Y_W-1:0] pend_y;
  logic [2:0]     pend_sel;
  logic           pend_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_x   <= '0;
      pend_y   <= '0;
      pend_sel <= '0;
      pend_en  <= 1'b0;
    end else if (ctl_we) begin
      case (ctl_addr)
        3'd0: pend_x <= wdata[X_W-1:0];
        3'd1: pend_y <= wdata[Y_W-1:0];
        3'd2: begin
          pend_sel <= wdata[2:0];
          pend_en  <= wdata[3];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_x   <= '0;
      act_y   <= '0;
      act_sel <= '0;
      act_en  <= 1'b0;
    end else if (field_start) begin
      act_x   <= pend_x;
      act_y   <= pend_y;
      act_sel <= pend_sel;
      act_en  <= pend_en;
    end
  end

  for (genvar g = 0; g < CLUT_N; g++) begin : g_entry
    logic hit_w;
    assign hit_w = ctl_we && ctl_addr[2] && (ctl_addr[1:0] == 2'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     clut[g] <= '0;
      else if (hit_w) clut[g] <= clut_entry_t'(wdata);
    end
  end
endmodule

// File: rtl/cursor_shape_mem.sv
module cursor_shape_mem
  import cursor_pkg::*;
#(
  parameter int DEPTH = 1 << CUR_ALOG
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [$clog2(DEPTH)-1:0]   waddr,
  input  logic [1:0]                 wdata,
  input  logic [$clog2(DEPTH)-1:0]   raddr,
  output logic [1:0]                 rdata
);
  logic [1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/cursor_hit.sv
module cursor_hit
  import cursor_pkg::*;
#(
  parameter int X_W = 11,
  parameter int Y_W = 10
) (
  input  logic [X_W-1:0]      pix_x,
  input  logic [Y_W-1:0]      pix_y,
  input  logic [X_W-1:0]      pos_x,
  input  logic [Y_W-1:0]      pos_y,
  input  logic [2:0]          sel,
  output logic                hit,
  output logic [CUR_ALOG-1:0] addr
);
  logic [3:0]   wlog;
  logic [3:0]   hlog;
  logic [X_W:0] dx;
  logic [Y_W:0] dy;
  logic [X_W:0] span_x;
  logic [Y_W:0] span_y;
  logic         in_x;
  logic         in_y;

  always_comb begin
    wlog   = width_log(sel);
    hlog   = height_log(sel);
    dx     = {1'b0, pix_x} - {1'b0, pos_x};
    dy     = {1'b0, pix_y} - {1'b0, pos_y};
    span_x = (X_W+1)'(1) << wlog;
    span_y = (Y_W+1)'(1) << hlog;
    in_x   = (pix_x >= pos_x) && (dx < span_x);
    in_y   = (pix_y >= pos_y) && (dy < span_y);
    hit    = in_x && in_y;
    addr   = CUR_ALOG'((32'(dy) << wlog) + 32'(dx));
  end
endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
  import cursor_pkg::*;
(
  input  logic                     hit,
  input  logic [1:0]               idx,
  input  clut_entry_t [CLUT_N-1:0] clut,
  input  logic [7:0]               in_y,
  input  logic [7:0]               in_u,
  input  logic [7:0]               in_v,
  output logic [7:0]               cur_y,
  output logic [7:0]               cur_u,
  output logic [7:0]               cur_v,
  output logic [1:0]               cur_t,
  output logic [7:0]               mix_y,
  output logic [7:0]               mix_u,
  output logic [7:0]               mix_v
);
  clut_entry_t ent;

  always_comb begin
    ent   = clut[idx];
    cur_y = widen6(ent.y);
    cur_u = widen4(ent.u);
    cur_v = widen4(ent.v);
    cur_t = ent.t;
    if (hit) begin
      mix_y = blend3(cur_y, in_y, cur_t);
      mix_u = blend3(cur_u, in_u, cur_t);
      mix_v = blend3(cur_v, in_v, cur_t);
    end else begin
      mix_y = in_y;
      mix_u = in_u;
      mix_v = in_v;
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int X_W = 11,
  parameter int Y_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_valid,
  input  logic [X_W-1:0] pix_x,
  input  logic [Y_W-1:0] pix_y,
  input  logic           field_start,
  input  logic [7:0]     in_y,
  input  logic [7:0]     in_u,
  input  logic [7:0]     in_v,
  input  logic           reg_we,
  input  logic [10:0]    reg_addr,
  input  logic [15:0]    reg_wdata,
  output logic           out_valid,
  output logic [7:0]     out_y,
  output logic [7:0]     out_u,
  output logic [7:0]     out_v
);
  logic [X_W-1:0]           act_x;
  logic [Y_W-1:0]           act_y;
  logic [2:0]               act_sel;
  logic                     act_en;
  clut_entry_t [CLUT_N-1:0] clut;

  logic                     ctl_we;
  logic                     cell_we;
  logic                     hit_s0;
  logic [CUR_ALOG-1:0]      addr_s0;

  logic                     vld_s1;
  logic                     hit_s1;
  logic [1:0]               idx_s1;
  logic [7:0]               y_s1, u_s1, v_s1;

  logic [7:0]               cur_y, cur_u, cur_v;
  logic [1:0]               cur_t;
  logic [7:0]               mix_y, mix_u, mix_v;

  assign ctl_we  = reg_we && !reg_addr[10];
  assign cell_we = reg_we &&  reg_addr[10];

  cursor_regs #(.X_W(X_W), .Y_W(Y_W)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_addr   (reg_addr[2:0]),
    .wdata      (reg_wdata),
    .field_start(field_start),
    .act_x      (act_x),
    .act_y      (act_y),
    .act_sel    (act_sel),
    .act_en     (act_en),
    .clut       (clut)
  );

  cursor_hit #(.X_W(X_W), .Y_W(Y_W)) i_hit (
    .pix_x(pix_x),
    .pix_y(pix_y),
    .pos_x(act_x),
    .pos_y(act_y),
    .sel  (act_sel),
    .hit  (hit_s0),
    .addr (addr_s0)
  );

  cursor_shape_mem #(.DEPTH(1 << CUR_ALOG)) i_mem (
    .clk  (clk),
    .we   (cell_we),
    .waddr(reg_addr[CUR_ALOG-1:0]),
    .wdata(reg_wdata[1:0]),
    .raddr(addr_s0),
    .rdata(idx_s1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_s1 <= 1'b0;
      hit_s1 <= 1'b0;
      y_s1   <= '0;
      u_s1   <= '0;
      v_s1   <= '0;
    end else begin
      vld_s1 <= pix_valid;
      hit_s1 <= hit_s0 && act_en;
      y_s1   <= in_y;
      u_s1   <= in_u;
      v_s1   <= in_v;
    end
  end

  cursor_mix i_mix (
    .hit  (hit_s1),
    .idx  (idx_s1),
    .clut (clut),
    .in_y (y_s1),
    .in_u (u_s1),
    .in_v (v_s1),
    .cur_y(cur_y),
    .cur_u(cur_u),
    .cur_v(cur_v),
    .cur_t(cur_t),
    .mix_y(mix_y),
    .mix_u(mix_u),
    .mix_v(mix_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_y     <= '0;
      out_u     <= '0;
      out_v     <= '0;
    end else begin
      out_valid <= vld_s1;
      out_y     <= mix_y;
      out_u     <= mix_u;
      out_v     <= mix_v;
    end
  end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int X_W = 11,
  parameter int Y_W = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pix_valid,
  input logic           field_start,
  input logic           vld_s1,
  input logic           hit_s1,
  input logic [1:0]     cur_t,
  input logic [7:0]     cur_y,
  input logic [7:0]     cur_u,
  input logic [7:0]     cur_v,
  input logic [7:0]     y_s1,
  input logic [7:0]     u_s1,
  input logic [7:0]     v_s1,
  input logic           out_valid,
  input logic [7:0]     out_y,
  input logic [7:0]     out_u,
  input logic [7:0]     out_v,
  input logic [X_W-1:0] act_x,
  input logic [Y_W-1:0] act_y,
  input logic [2:0]     act_sel,
  input logic           act_en
);
  // R2: the qualifier moves one stage per edge
  assert_valid_stage1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> vld_s1);
  assert_valid_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_s1 |=> out_valid);
  assert_invalid_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_s1 |=> !out_valid);

  // R3: a pixel with no hit leaves unchanged
  assert_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_s1 |=> (out_y == $past(y_s1) && out_u == $past(u_s1) && out_v == $past(v_s1)));

  // R7: the two end levels of opacity
  assert_clear_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_s1 && cur_t == 2'd0) |=> (out_y == $past(y_s1) && out_u == $past(u_s1) && out_v == $past(v_s1)));
  assert_solid_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_s1 && cur_t == 2'd3) |=> (out_y == $past(cur_y) && out_u == $past(cur_u) && out_v == $past(cur_v)));

  // R8: active settings move only on a field start
  assert_hold_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> ($stable(act_x) && $stable(act_y) && $stable(act_sel) && $stable(act_en)));
endmodule

bind cursor_overlay cursor_overlay_chk #(.X_W(X_W), .Y_W(Y_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_valid  (pix_valid),
  .field_start(field_start),
  .vld_s1     (vld_s1),
  .hit_s1     (hit_s1),
  .cur_t      (cur_t),
  .cur_y      (cur_y),
  .cur_u      (cur_u),
  .cur_v      (cur_v),
  .y_s1       (y_s1),
  .u_s1       (u_s1),
  .v_s1       (v_s1),
  .out_valid  (out_valid),
  .out_y      (out_y),
  .out_u      (out_u),
  .out_v      (out_v),
  .act_x      (act_x),
  .act_y      (act_y),
  .act_sel    (act_sel),
  .act_en     (act_en)
);

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;
  localparam int X_W = 11;
  localparam int Y_W = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           pix_valid = 1'b0;
  logic [X_W-1:0] pix_x = '0;
  logic [Y_W-1:0] pix_y = '0;
  logic           field_start = 1'b0;
  logic [7:0]     in_y = '0, in_u = '0, in_v = '0;
  logic           reg_we = 1'b0;
  logic [10:0]    reg_addr = '0;
  logic [15:0]    reg_wdata = '0;
  logic           out_valid;
  logic [7:0]     out_y, out_u, out_v;

  cursor_overlay #(.X_W(X_W), .Y_W(Y_W)) i_cursor_overlay (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .field_start(field_start), .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .out_valid(out_valid), .out_y(out_y), .out_u(out_u), .out_v(out_v));

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string phase = "R1";

  // bench model of the programmed state
  int pend_x = 0, pend_y = 0, pend_ctl = 0;
  int act_x = 0, act_y = 0, act_sel = 0, act_en = 0;
  int clut_m [4];
  int cell_m [1024];

  // two-deep history of expectations
  bit e_v [2];
  bit e_h [2];
  int e_y [2], e_u [2], e_v8 [2];

  function automatic int mixc(int c, int p, int t);
    return (c * t + p * (3 - t)) / 3;
  endfunction

  task automatic expect_px(input int x, input int y, input int yi, input int ui, input int vi,
                           output bit h, output int ey, output int eu, output int ev);
    int s, w, hh, a, e, t;
    s  = (act_sel > 4) ? 4 : act_sel;
    w  = 8 * (1 << s);
    hh = 1024 / w;
    h  = (act_en != 0) && x >= act_x && x < act_x + w && y >= act_y && y < act_y + hh;
    ey = yi; eu = ui; ev = vi;
    if (h) begin
      a  = (y - act_y) * w + (x - act_x);
      e  = clut_m[cell_m[a]];
      t  = e % 4;
      ey = mixc(((e / 1024) % 64) * 4 + ((e / 1024) % 64) / 16, yi, t);
      eu = mixc(((e / 64) % 16) * 17, ui, t);
      ev = mixc(((e / 4) % 16) * 17, vi, t);
    end
  endtask

  task automatic count(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  // one cycle: check output due now, then drive the next input
  task automatic step(input bit val, input int x, input int y);
    int yi, ui, vi;
    bit h;
    int ey, eu, ev;
    count(out_valid == e_v[1], "R2 valid", int'(out_valid), int'(e_v[1]));
    if (e_v[1])
      count(out_y == e_y[1][7:0] && out_u == e_u[1][7:0] && out_v == e_v8[1][7:0],
            e_h[1] ? "R7 blend" : "R3 pass",
            int'({out_y, out_u, out_v}), (e_y[1] << 16) | (e_u[1] << 8) | e_v8[1]);
    yi = (x * 3 + y * 7) % 256;
    ui = (x + y * 5 + 40) % 256;
    vi = (x ^ (y * 3)) % 256;
    expect_px(x, y, yi, ui, vi, h, ey, eu, ev);
    e_v[1] = e_v[0]; e_h[1] = e_h[0]; e_y[1] = e_y[0]; e_u[1] = e_u[0]; e_v8[1] = e_v8[0];
    e_v[0] = val;    e_h[0] = h;      e_y[0] = ey;     e_u[0] = eu;     e_v8[0] = ev;
    pix_valid = val;
    pix_x = X_W'(x);
    pix_y = Y_W'(y);
    in_y = 8'(yi); in_u = 8'(ui); in_v = 8'(vi);
    @(negedge clk);
  endtask

  task automatic wr(input int addr, input int data);
    reg_we = 1'b1;
    reg_addr = 11'(addr);
    reg_wdata = 16'(data);
    step(1'b0, 0, 0);
    reg_we = 1'b0;
    if (addr >= 1024) cell_m[addr - 1024] = data % 4;
    else case (addr % 8)
      0: pend_x = data;
      1: pend_y = data;
      2: pend_ctl = data;
      4, 5, 6, 7: clut_m[addr % 4] = data;
      default: ;
    endcase
  endtask

  task automatic fstart(input bit val, input int x, input int y);
    field_start = 1'b1;
    step(val, x, y);
    field_start = 1'b0;
    act_x = pend_x; act_y = pend_y; act_sel = pend_ctl % 8; act_en = (pend_ctl / 8) % 2;
  endtask

  function automatic int ent(int y6, int u4, int v4, int t2);
    return y6 * 1024 + u4 * 64 + v4 * 4 + t2;
  endfunction

  task automatic sweep(input int sel, input int px, input int py);
    int s, w, hh;
    s = (sel > 4) ? 4 : sel;
    w = 8 << s;
    hh = 1024 / w;
    wr(0, px); wr(1, py); wr(2, 8 + sel);
    fstart(1'b0, 0, 0);
    for (int y = py - 2; y < py + hh + 2; y++)
      for (int x = px - 2; x < px + w + 2; x++)
        step(1'b1, x, y);
    for (int i = 0; i < 3; i++) step(1'b0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin e_v[i] = 0; e_h[i] = 0; e_y[i] = 0; e_u[i] = 0; e_v8[i] = 0; end
    for (int i = 0; i < 4; i++) clut_m[i] = 0;
    for (int i = 0; i < 1024; i++) cell_m[i] = 0;
    repeat (3) @(negedge clk);
    phase = "R1";
    count(out_valid == 1'b0 && out_y == 8'd0 && out_u == 8'd0 && out_v == 8'd0,
          "R1 reset outputs", int'({out_valid, out_y, out_u, out_v}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 12; i++) step(1'b1, i, i % 3);
    step(1'b0, 0, 0);

    phase = "R5 load";
    for (int a = 0; a < 1024; a++) wr(1024 + a, (a ^ (a >> 3) ^ (a >> 7)) % 4);
    phase = "R6 load";
    for (int i = 0; i < 4; i++) wr(4 + i, ent((i * 21 + 5) % 64, (i * 5 + 3) % 16, 15 - i * 4, i));

    phase = "R8";
    wr(0, 40); wr(1, 30); wr(2, 8 + 2);
    for (int x = 38; x < 46; x++) step(1'b1, x, 30);
    fstart(1'b1, 41, 31);
    for (int x = 38; x < 46; x++) step(1'b1, x, 31);
    wr(0, 200);
    for (int x = 38; x < 46; x++) step(1'b1, x, 32);
    step(1'b0, 0, 0);

    for (int s = 0; s < 5; s++) begin
      phase = $sformatf("R4/R5 shape%0d", s);
      sweep(s, 30 + s * 60, 20 + s * 9);
    end
    phase = "R4 clamp";
    sweep(7, 100, 500);

    phase = "R6";
    wr(4, ent(63, 15, 0, 3)); wr(5, ent(1, 1, 8, 3));
    wr(6, ent(32, 7, 15, 2)); wr(7, ent(0, 0, 15, 1));
    sweep(2, 300, 400);

    phase = "R9";
    wr(4, ent(10, 9, 2, 3));
    for (int x = 300; x < 310; x++) step(1'b1, x, 400);
    wr(1024 + 0, 1);
    step(1'b1, 300, 400);
    wr(1024 + 0, 3);
    step(1'b1, 300, 400);
    for (int i = 0; i < 3; i++) step(1'b0, 0, 0);

    phase = "R10";
    wr(0, 2040); wr(1, 1016); wr(2, 8 + 2);
    fstart(1'b0, 0, 0);
    for (int y = 1014; y < 1024; y++) begin
      for (int x = 2034; x < 2048; x++) step(1'b1, x, y);
      for (int x = 0; x < 6; x++) step(1'b1, x, y);
    end
    for (int y = 0; y < 4; y++)
      for (int x = 2040; x < 2048; x++) step(1'b1, x, y);
    for (int i = 0; i < 3; i++) step(1'b0, 0, 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule